// File: doc/BRIEF.md
# RS-485 Multidrop Receive Address Filter

This block sits between a 9-bit UART receive deserializer and the receive FIFO of a multidrop serial node. For every character the deserializer presents, the filter decides whether the character goes into the FIFO. It also raises the data-ready and address (parity-error) interrupt requests. The ninth bit of each character tells an address character (ninth bit 1) from a data character (ninth bit 0). The FIFO entry is nine bits wide, with the ninth bit in the top position.

The block holds a three-bit control register and an 8-bit address match register. Software loads both through simple write strobes. In normal multidrop mode, software opens and closes the receiver itself after it sees an address. In automatic address detection mode, the filter compares each incoming address with the match register. A matching address opens the receiver in hardware. A foreign address closes the receiver in hardware. This lets a node skip the frames meant for other stations without any software involvement.

All outputs are registered. A character presented with `rx_valid` in cycle t shows its effects on the outputs, and on the control register, in cycle t+1.

Top module: `mdrop_rx_filter`

## Requirements
- R1: After reset the control register (`ctl_q`) reads 0, the match register holds 0x00, and `fifo_push`, `irq_rdy`, `irq_addr`, `rxen_clr` and `rxoff_set` are low.
- R2: With control bit 0 (multidrop enable) clear, every character is pushed one cycle after `rx_valid`, with `fifo_data` = {ninth bit, byte} and an `irq_rdy` pulse. `irq_addr` stays low. With no `rx_valid`, nothing is pushed.
- R3: In normal multidrop mode (bit 0 = 1, bit 2 = 0) with the receiver off (control bit 1 = 1), data characters are dropped. Address characters are pushed and pulse `irq_rdy`.
- R4: In normal multidrop mode with the receiver on (bit 1 = 0), every character is pushed with `irq_rdy`. An address character also pulses `irq_addr`.
- R5: In auto-detect mode (bits 0 and 2 both set) with the receiver off, data characters are discarded. Address characters whose byte differs from the match register are also discarded.
- R6: In auto-detect mode, an address equal to the match register is pushed with its ninth bit and pulses `irq_rdy`. It also pulses `rxen_clr` and clears control bit 1.
- R7: In auto-detect mode with the receiver on, data characters are pushed with `irq_rdy`. A non-matching address is not pushed: it pulses `rxoff_set` and sets control bit 1.
- R8: When a hardware clear or set of bit 1 coincides with a software write, the hardware value of bit 1 wins. Bits 0 and 2 take the written value. The updated register governs the next character.
- R9: Setting bit 2 without bit 0 behaves exactly as plain mode (R2).
- R10: A write with `match_we` loads `match_wdata` into the match register. The new value is used for the compares that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received character strobe |
| rx_byte | input | DATA_W | Received byte |
| rx_addr | input | 1 | Ninth bit: 1 = address character |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control value: bit 0 multidrop, bit 1 receiver off, bit 2 auto-detect |
| match_we | input | 1 | Match register write strobe |
| match_wdata | input | DATA_W | Match register value |
| fifo_push | output | 1 | Push strobe to the receive FIFO |
| fifo_data | output | DATA_W+1 | FIFO entry {ninth bit, byte} |
| irq_rdy | output | 1 | Receive-data-ready interrupt pulse |
| irq_addr | output | 1 | Address (parity-error) interrupt pulse |
| rxen_clr | output | 1 | Pulse: hardware cleared the receiver-off bit |
| rxoff_set | output | 1 | Pulse: hardware set the receiver-off bit |
| ctl_q | output | 3 | Current control register |

## Verification
The hardest situation to reach is a hardware update of the receiver-off bit that lands in the same cycle as a software write to the control register. The bench raises `cfg_we` in the very cycle in which it presents a matching or a foreign address. It then reads `ctl_q` to confirm that bit 1 follows the hardware while bits 0 and 2 follow the write. Apart from that, the bench sweeps all eight control values against both ninth-bit values, bytes equal to and one off the match value, and two match values. It predicts every output from the mode rules.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  localparam int CTRL_W = 3;

  // bit 2: auto-detect, bit 1: receiver off, bit 0: multidrop enable
  typedef struct packed {
    logic auto_en;
    logic rx_off;
    logic md_en;
  } ctrl_t;

  typedef struct packed {
    logic push;
    logic rdy;
    logic perr;
    logic hw_clr;
    logic hw_set;
  } verdict_t;
endpackage

// File: rtl/mdrop_cfg_regs.sv
module mdrop_cfg_regs
  import mdrop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              match_we,
  input  logic [DATA_W-1:0] match_wdata,
  input  logic              hw_clr,
  input  logic              hw_set,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] match_val
);
  ctrl_t ctrl_r, ctrl_nx;
  logic [DATA_W-1:0] match_r;

  always_comb begin
    ctrl_nx = ctrl_r;
    if (cfg_we) ctrl_nx = ctrl_t'(cfg_wdata);
    // hardware update of the receiver-off bit overrides software
    if (hw_clr)      ctrl_nx.rx_off = 1'b0;
    else if (hw_set) ctrl_nx.rx_off = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_r  <= '0;
      match_r <= '0;
    end else begin
      ctrl_r <= ctrl_nx;
      if (match_we) match_r <= match_wdata;
    end
  end

  assign ctrl      = ctrl_r;
  assign match_val = match_r;
endmodule

// File: rtl/mdrop_decide.sv
module mdrop_decide
  import mdrop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              valid,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              is_addr,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] match_val,
  output verdict_t          verdict
);
  logic auto_mode, hit;

  assign auto_mode = ctrl.md_en & ctrl.auto_en;
  assign hit       = is_addr & (byte_in == match_val);

  always_comb begin
    verdict = '0;
    if (valid) begin
      if (!ctrl.md_en) begin
        verdict.push = 1'b1;
      end else if (!auto_mode) begin
        verdict.push = is_addr | ~ctrl.rx_off;
        verdict.perr = is_addr & ~ctrl.rx_off;
      end else if (hit) begin
        verdict.push   = 1'b1;
        verdict.hw_clr = 1'b1;
      end else if (!ctrl.rx_off) begin
        verdict.push   = ~is_addr;
        verdict.hw_set = is_addr;
      end
      verdict.rdy = verdict.push;
    end
  end
endmodule

// File: rtl/mdrop_out_reg.sv
module mdrop_out_reg
  import mdrop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  verdict_t          verdict,
  input  logic [DATA_W:0]   entry,
  output logic              push,
  output logic [DATA_W:0]   data,
  output logic              rdy,
  output logic              perr,
  output logic              clr,
  output logic              set
);
  always_ff @(posedge clk) begin
    if (rst) begin
      push <= 1'b0;
      data <= '0;
      rdy  <= 1'b0;
      perr <= 1'b0;
      clr  <= 1'b0;
      set  <= 1'b0;
    end else begin
      push <= verdict.push;
      rdy  <= verdict.rdy;
      perr <= verdict.perr;
      clr  <= verdict.hw_clr;
      set  <= verdict.hw_set;
      if (verdict.push) data <= entry;
    end
  end
endmodule

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter
  import mdrop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_addr,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_wdata,
  input  logic              match_we,
  input  logic [DATA_W-1:0] match_wdata,
  output logic              fifo_push,
  output logic [DATA_W:0]   fifo_data,
  output logic              irq_rdy,
  output logic              irq_addr,
  output logic              rxen_clr,
  output logic              rxoff_set,
  output logic [2:0]        ctl_q
);
  localparam int ENTRY_W = DATA_W + 1;

  ctrl_t             ctrl;
  logic [DATA_W-1:0] match_q;
  verdict_t          verdict;
  logic [ENTRY_W-1:0] entry;

  assign entry = {rx_addr, rx_byte};

  mdrop_cfg_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .match_we(match_we), .match_wdata(match_wdata),
    .hw_clr(verdict.hw_clr), .hw_set(verdict.hw_set),
    .ctrl(ctrl), .match_val(match_q)
  );

  mdrop_decide #(.DATA_W(DATA_W)) u_decide (
    .valid(rx_valid), .byte_in(rx_byte), .is_addr(rx_addr),
    .ctrl(ctrl), .match_val(match_q), .verdict(verdict)
  );

  mdrop_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .verdict(verdict), .entry(entry),
    .push(fifo_push), .data(fifo_data), .rdy(irq_rdy),
    .perr(irq_addr), .clr(rxen_clr), .set(rxoff_set)
  );

  assign ctl_q = ctrl;
endmodule

module mdrop_rx_filter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_byte,
  input logic              rx_addr,
  input logic [DATA_W-1:0] match_val,
  input logic              fifo_push,
  input logic              irq_addr,
  input logic              rxen_clr,
  input logic              rxoff_set,
  input logic [2:0]        ctl_q
);
  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rx_valid) |-> !fifo_push);

  p_off_data_drop_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(rx_valid) && $past(ctl_q[0]) && $past(ctl_q[1]) && !$past(rx_addr))
      |-> !fifo_push);

  p_perr_stored_r4: assert property (@(posedge clk) disable iff (rst)
    irq_addr |-> fifo_push);

  p_mismatch_drop_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(rx_valid) && $past(ctl_q) == 3'b111 && $past(rx_addr)
      && $past(rx_byte) != $past(match_val)) |-> !fifo_push);

  p_hwclr_r6: assert property (@(posedge clk) disable iff (rst)
    rxen_clr |-> (!ctl_q[1] && fifo_push));

  p_hwset_r7: assert property (@(posedge clk) disable iff (rst)
    rxoff_set |-> (ctl_q[1] && !fifo_push));
endmodule

bind mdrop_rx_filter mdrop_rx_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
  .rx_addr(rx_addr), .match_val(match_q), .fifo_push(fifo_push),
  .irq_addr(irq_addr), .rxen_clr(rxen_clr), .rxoff_set(rxoff_set),
  .ctl_q(ctl_q)
);

// File: tb/mdrop_rx_filter_test.sv
module mdrop_rx_filter_test;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0, rx_addr = 1'b0, cfg_we = 1'b0, match_we = 1'b0;
  logic [DW-1:0] rx_byte = '0, match_wdata = '0;
  logic [2:0] cfg_wdata = '0;
  logic fifo_push, irq_rdy, irq_addr, rxen_clr, rxoff_set;
  logic [DW:0] fifo_data;
  logic [2:0] ctl_q;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mdrop_rx_filter #(.DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_addr(rx_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .match_we(match_we), .match_wdata(match_wdata),
    .fifo_push(fifo_push), .fifo_data(fifo_data), .irq_rdy(irq_rdy),
    .irq_addr(irq_addr), .rxen_clr(rxen_clr), .rxoff_set(rxoff_set),
    .ctl_q(ctl_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected behaviour from the mode rules (R2..R7, R9)
  task automatic predict(input logic [2:0] c, input logic a, input logic [7:0] b,
                         input logic [7:0] m, output logic [4:0] o,
                         output logic [2:0] nc);
    logic push, pe, clr, set;
    push = 0; pe = 0; clr = 0; set = 0; nc = c;
    if (!c[0]) push = 1;
    else if (!c[2]) begin push = a | !c[1]; pe = a & !c[1]; end
    else if (a && b == m) begin push = 1; clr = 1; nc[1] = 0; end
    else if (!c[1]) begin
      if (a) begin set = 1; nc[1] = 1; end else push = 1;
    end
    o = {push, push, pe, clr, set};
  endtask

  task automatic send(input logic [2:0] c, input logic [7:0] m, input logic a,
                      input logic [7:0] b, input string req);
    logic [4:0] o;
    logic [2:0] nc;
    @(negedge clk);
    cfg_we = 1; cfg_wdata = c; match_we = 1; match_wdata = m;
    @(negedge clk);
    cfg_we = 0; match_we = 0;
    rx_valid = 1; rx_addr = a; rx_byte = b;
    @(negedge clk);
    rx_valid = 0;
    predict(c, a, b, m, o, nc);
    chk({req, " push"}, fifo_push, o[4]);
    if (o[4]) chk({req, " data"}, fifo_data, {a, b});
    chk({req, " rdy"}, irq_rdy, o[3]);
    chk({req, " perr"}, irq_addr, o[2]);
    chk({req, " clr"}, rxen_clr, o[1]);
    chk({req, " set"}, rxoff_set, o[0]);
    chk({req, " ctl"}, ctl_q, nc);
    @(negedge clk);
    chk("R2 idle push", fifo_push, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 ctl", ctl_q, 0);
    chk("R1 push", fifo_push, 0);
    chk("R1 irq", {irq_rdy, irq_addr, rxen_clr, rxoff_set}, 0);
    // R1/R10: match register resets to 0x00, seen via a hit on address 0
    @(negedge clk); cfg_we = 1; cfg_wdata = 3'b111;
    @(negedge clk); cfg_we = 0; rx_valid = 1; rx_addr = 1; rx_byte = 8'h00;
    @(negedge clk); rx_valid = 0;
    chk("R1 match reset hit", fifo_push, 1);
    chk("R1 match reset clr", ctl_q, 3'b101);

    // Sweep R2..R7, R9, R10
    for (int c = 0; c < 8; c++)
      for (int mi = 0; mi < 2; mi++)
        for (int a = 0; a < 2; a++)
          for (int bi = 0; bi < 3; bi++) begin
            logic [7:0] m, b;
            string req;
            m = (mi == 0) ? 8'h5A : 8'hC3;
            b = (bi == 0) ? m : (bi == 1) ? (m ^ 8'h01) : 8'h00;
            if (!c[0]) req = c[2] ? "R9" : "R2";
            else if (!c[2]) req = c[1] ? "R3" : "R4";
            else if (a == 1 && bi == 0) req = "R6";
            else req = c[1] ? "R5" : "R7";
            if (mi == 1) req = {req, "/R10"};
            send(c[2:0], m, a[0], b, req);
          end

    // R8: hw clear beats a simultaneous software write of bit 1
    send(3'b111, 8'h33, 1'b0, 8'h00, "R8 setup");
    @(negedge clk); cfg_we = 1; cfg_wdata = 3'b111; rx_valid = 1; rx_addr = 1; rx_byte = 8'h33;
    @(negedge clk); cfg_we = 0; rx_valid = 0;
    chk("R8 clr wins", ctl_q, 3'b101);
    // R8: hw set beats a write of bit 1 = 0; bit 2 from software is ignored
    // here only for bit 1 (software writes 101, hardware sets bit 1)
    @(negedge clk); cfg_we = 1; cfg_wdata = 3'b101; rx_valid = 1; rx_addr = 1; rx_byte = 8'h34;
    @(negedge clk); cfg_we = 0; rx_valid = 0;
    chk("R8 set wins", ctl_q, 3'b111);
    chk("R8 set pulse", rxoff_set, 1);
    // R8: the new value governs the next character (receiver now off)
    @(negedge clk); rx_valid = 1; rx_addr = 0; rx_byte = 8'h10;
    @(negedge clk); rx_valid = 0;
    chk("R8 next char dropped", fifo_push, 0);
    // R8: software bits 0/2 taken on a concurrent hw clear
    @(negedge clk); cfg_we = 1; cfg_wdata = 3'b011; rx_valid = 1; rx_addr = 1; rx_byte = 8'h33;
    @(negedge clk); cfg_we = 0; rx_valid = 0;
    chk("R8 sw bits kept", ctl_q, 3'b001);
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 20000) begin @(posedge clk); n++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule